// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the coherence directory at one memory home node of a distributed-memory multiprocessor. For every memory block that lives at the node it keeps a coherence state (Uncached, Shared or Exclusive) and a presence vector with one bit per processor. It also holds the block's data in a small local store. Caches send it read-miss, write-miss and write-back requests. Each request names the requesting processor and the block. The controller handles one request at a time. It updates the entry and then issues point-to-point messages on a single output port: a data reply, an invalidate, a fetch, or a fetch-and-invalidate. Nothing is broadcast.

A request is accepted in any cycle where `busy` is low and `req_valid` is high. When a block is held Exclusive, the controller recalls it from the owner with a fetch message and waits on `fetch_valid`, keeping `busy` high while it waits. Invalidates go out one per cycle, lowest processor number first, and the data reply always comes last. The network, the caches and buffer deadlock handling lie outside the block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is Uncached, its presence vector is empty and its data is zero, and `busy` and `msg_valid` are low. `busy` is high from the cycle after a request is accepted until its last message has been issued.
- R2: A read miss (request code 0) to an Uncached block issues one data reply (message code 0) to the requester, carrying the stored data. The block becomes Shared with only the requester present.
- R3: A read miss to a Shared block issues one data reply with the stored data and adds the requester to the presence vector.
- R4: A write miss (request code 1) to an Uncached block issues one data reply with the stored data. The block becomes Exclusive with the requester as sole owner.
- R5: A write miss to a Shared block first issues an invalidate (message code 1) to every present processor other than the requester, one per cycle in ascending processor order. It then issues the data reply. The block becomes Exclusive, owned by the requester.
- R6: A read miss to an Exclusive block issues a fetch (message code 2) to the owner. The data returned on `fetch_data` is written to the store and sent to the requester in a data reply. The block becomes Shared, with both the old owner and the requester present.
- R7: A write miss to an Exclusive block issues a fetch-and-invalidate (message code 3) to the owner. The returned data is forwarded to the requester in a data reply. The requester becomes sole owner and the block stays Exclusive.
- R8: A write-back (request code 2) from the owner of an Exclusive block stores `req_data`, empties the presence vector and makes the block Uncached, with no message issued.
- R9: A write-back from a processor that does not own the block in Exclusive state issues no message and changes neither the entry nor the stored data.
- R10: A request presented while `busy` is high, including while a fetch response is awaited, is ignored and produces no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_proc | input | 2 | Requesting processor number |
| req_addr | input | 4 | Block index |
| req_data | input | 32 | Write-back data |
| busy | output | 1 | High while a request is in progress; new requests are ignored |
| fetch_valid | input | 1 | Owner's data returned for a fetch |
| fetch_data | input | 32 | Returned block data |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_type | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_proc | output | 2 | Destination processor |
| msg_addr | output | 4 | Block index |
| msg_data | output | 32 | Reply data; zero for other message codes |

## Verification
A short directed walk takes one block through every state and transition. Two long pseudo-random streams then follow, one on four blocks and one on all sixteen. Each request's full message sequence is compared with an arithmetic model of the directory. The narrow stream produces many Shared blocks with several sharers, which tests that invalidates skip the requester and come out in ascending order. The wide stream tests that entries are separate. Fetch responses arrive with a variable delay, and dummy requests are driven while the controller waits, so ignored traffic can be told apart from real traffic. Write-backs from non-owners show whether ownership is checked.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_EXC = 2'd2
  } dstate_t;

  localparam logic [1:0] RQ_RD = 2'd0;
  localparam logic [1:0] RQ_WR = 2'd1;
  localparam logic [1:0] RQ_WB = 2'd2;

  localparam logic [1:0] MT_DATA  = 2'd0;
  localparam logic [1:0] MT_INV   = 2'd1;
  localparam logic [1:0] MT_FETCH = 2'd2;
  localparam logic [1:0] MT_FINV  = 2'd3;

  typedef enum logic [2:0] {
    F_IDLE  = 3'd0,
    F_EXEC  = 3'd1,
    F_INV   = 3'd2,
    F_FREQ  = 3'd3,
    F_FWAIT = 3'd4,
    F_REPLY = 3'd5
  } fsm_t;

endpackage

// File: rtl/dir_lowest_pick.sv
module dir_lowest_pick #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  onehot
);

  // scan from the top down so the lowest set bit is the one left standing
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx       = IW'(i);
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NENT  = 16,
  parameter int DW    = 32,
  localparam int AW   = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [AW-1:0]    rd_addr,
  output dstate_t          rd_state,
  output logic [NPROC-1:0] rd_sharers,
  output logic [DW-1:0]    rd_data,
  input  logic             dir_we,
  input  logic [AW-1:0]    dir_waddr,
  input  dstate_t          dir_wstate,
  input  logic [NPROC-1:0] dir_wsharers,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_waddr,
  input  logic [DW-1:0]    mem_wdata
);

  dstate_t          st_q  [NENT];
  logic [NPROC-1:0] sh_q  [NENT];
  logic [DW-1:0]    dat_q [NENT];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NENT; e++) begin
        st_q[e]  <= DS_UNC;
        sh_q[e]  <= '0;
        dat_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NENT; e++) begin
        if (dir_we && (dir_waddr == AW'(e))) begin
          st_q[e] <= dir_wstate;
          sh_q[e] <= dir_wsharers;
        end
        if (mem_we && (mem_waddr == AW'(e))) begin
          dat_q[e] <= mem_wdata;
        end
      end
    end
  end

  assign rd_state   = st_q[rd_addr];
  assign rd_sharers = sh_q[rd_addr];
  assign rd_data    = dat_q[rd_addr];

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NENT  = 16,
  parameter int DW    = 32,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW   = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_type,
  input  logic [PW-1:0] req_proc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  input  logic          fetch_valid,
  input  logic [DW-1:0] fetch_data,
  output logic          msg_valid,
  output logic [1:0]    msg_type,
  output logic [PW-1:0] msg_proc,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // state and captured request
  fsm_t             fsm_q, fsm_d;
  logic [1:0]       q_type;
  logic [PW-1:0]    q_proc;
  logic [AW-1:0]    q_addr;
  logic [DW-1:0]    q_data;
  logic [NPROC-1:0] mask_q, mask_d;
  logic [PW-1:0]    owner_q, owner_d;
  logic             accept;

  // store interface
  dstate_t          rd_state;
  logic [NPROC-1:0] rd_sharers;
  logic [DW-1:0]    rd_data;
  logic             dir_we;
  dstate_t          dir_wstate;
  logic [NPROC-1:0] dir_wsharers;
  logic             mem_we;
  logic [DW-1:0]    mem_wdata;

  // lowest-set-bit picker, shared by owner lookup and invalidate walk
  logic [NPROC-1:0] pick_vec;
  logic [PW-1:0]    pick_idx;
  logic [NPROC-1:0] pick_oh;
  logic [NPROC-1:0] req_bit;
  logic [NPROC-1:0] others;

  assign req_bit  = NPROC'(1) << q_proc;
  assign others   = rd_sharers & ~req_bit;
  assign pick_vec = (fsm_q == F_INV) ? mask_q : rd_sharers;

  dir_lowest_pick #(.W(NPROC)) pick_i (
    .vec    (pick_vec),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  dir_store #(.NPROC(NPROC), .NENT(NENT), .DW(DW)) store_i (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .rd_addr      (q_addr),
    .rd_state     (rd_state),
    .rd_sharers   (rd_sharers),
    .rd_data      (rd_data),
    .dir_we       (dir_we),
    .dir_waddr    (q_addr),
    .dir_wstate   (dir_wstate),
    .dir_wsharers (dir_wsharers),
    .mem_we       (mem_we),
    .mem_waddr    (q_addr),
    .mem_wdata    (mem_wdata)
  );

  assign busy     = (fsm_q != F_IDLE);
  assign accept   = (fsm_q == F_IDLE) && req_valid;
  assign msg_addr = q_addr;

  // next-state and outputs
  always_comb begin
    fsm_d        = fsm_q;
    mask_d       = mask_q;
    owner_d      = owner_q;
    dir_we       = 1'b0;
    dir_wstate   = DS_UNC;
    dir_wsharers = '0;
    mem_we       = 1'b0;
    mem_wdata    = '0;
    msg_valid    = 1'b0;
    msg_type     = MT_DATA;
    msg_proc     = '0;
    msg_data     = '0;

    unique case (fsm_q)
      F_IDLE: begin
        if (req_valid) fsm_d = F_EXEC;
      end

      F_EXEC: begin
        if (q_type == RQ_WB) begin
          if ((rd_state == DS_EXC) && (rd_sharers == req_bit)) begin
            dir_we    = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = q_data;
          end
          fsm_d = F_IDLE;
        end else if ((q_type == RQ_RD) || (q_type == RQ_WR)) begin
          if (rd_state == DS_EXC) begin
            owner_d = pick_idx;
            fsm_d   = F_FREQ;
          end else if ((q_type == RQ_WR) && (rd_state == DS_SHR) && (others != '0)) begin
            mask_d = others;
            fsm_d  = F_INV;
          end else begin
            fsm_d = F_REPLY;
          end
        end else begin
          fsm_d = F_IDLE;
        end
      end

      F_INV: begin
        msg_valid = 1'b1;
        msg_type  = MT_INV;
        msg_proc  = pick_idx;
        mask_d    = mask_q & ~pick_oh;
        if ((mask_q & ~pick_oh) == '0) fsm_d = F_REPLY;
      end

      F_FREQ: begin
        msg_valid = 1'b1;
        msg_type  = (q_type == RQ_WR) ? MT_FINV : MT_FETCH;
        msg_proc  = owner_q;
        fsm_d     = F_FWAIT;
      end

      F_FWAIT: begin
        if (fetch_valid) begin
          mem_we    = 1'b1;
          mem_wdata = fetch_data;
          fsm_d     = F_REPLY;
        end
      end

      F_REPLY: begin
        msg_valid = 1'b1;
        msg_type  = MT_DATA;
        msg_proc  = q_proc;
        msg_data  = rd_data;
        dir_we    = 1'b1;
        if (q_type == RQ_WR) begin
          dir_wstate   = DS_EXC;
          dir_wsharers = req_bit;
        end else begin
          dir_wstate   = DS_SHR;
          dir_wsharers = rd_sharers | req_bit;
        end
        fsm_d = F_IDLE;
      end

      default: fsm_d = F_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= F_IDLE;
      mask_q  <= '0;
      owner_q <= '0;
    end else begin
      fsm_q   <= fsm_d;
      mask_q  <= mask_d;
      owner_q <= owner_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_type <= '0;
      q_proc <= '0;
      q_addr <= '0;
      q_data <= '0;
    end else if (accept) begin
      q_type <= req_type;
      q_proc <= req_proc;
      q_addr <= req_addr;
      q_data <= req_data;
    end
  end

  // ---------------- assertions ----------------
  assert_inv_order_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (msg_valid && (msg_type == MT_INV)) |=>
      (msg_valid && ((msg_type == MT_DATA) ||
                     ((msg_type == MT_INV) && (msg_proc > $past(msg_proc))))));

  assert_inv_skips_req_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (msg_valid && (msg_type == MT_INV)) |-> (msg_proc != q_proc));

  assert_fetch_then_reply_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    ((fsm_q == F_FWAIT) && fetch_valid) |=>
      (msg_valid && (msg_type == MT_DATA) && (msg_data == $past(fetch_data))));

  assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (dir_we && (dir_wstate == DS_EXC)) |-> ($countones(dir_wsharers) == 1));

  assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> ($stable(q_proc) && $stable(q_addr) && $stable(q_type)));

  assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> !msg_valid);

  assert_fetch_busy_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (msg_valid && ((msg_type == MT_FETCH) || (msg_type == MT_FINV))) |=> busy);

endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb_top;

  localparam int NP = 4;
  localparam int NE = 16;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_type;
  logic [1:0]  req_proc;
  logic [3:0]  req_addr;
  logic [31:0] req_data;
  logic        busy;
  logic        fetch_valid;
  logic [31:0] fetch_data;
  logic        msg_valid;
  logic [1:0]  msg_type;
  logic [1:0]  msg_proc;
  logic [3:0]  msg_addr;
  logic [31:0] msg_data;

  int n_tests = 0;
  int n_fail  = 0;

  dir_home_ctrl #(.NPROC(NP), .NENT(NE), .DW(32)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_type(req_type), .req_proc(req_proc),
    .req_addr(req_addr), .req_data(req_data), .busy(busy),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_proc(msg_proc),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // model: 0 Uncached, 1 Shared, 2 Exclusive
  int          m_st  [NE];
  logic [3:0]  m_sh  [NE];
  logic [31:0] m_mem [NE];

  // expected and observed messages: {type, proc, addr, data}
  logic [1:0]  e_t [8]; logic [1:0] e_p [8]; logic [31:0] e_d [8];
  logic [1:0]  o_t [8]; logic [1:0] o_p [8]; logic [3:0] o_a [8]; logic [31:0] o_d [8];
  int          e_n, o_n;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [1:0] t, input logic [1:0] p, input logic [31:0] d);
    e_t[e_n] = t; e_p[e_n] = p; e_d[e_n] = d; e_n++;
  endtask

  function automatic int owner_of(input logic [3:0] v);
    for (int i = NP - 1; i >= 0; i--) if (v[i]) owner_of = i;
  endfunction

  task automatic do_req(input logic [1:0] t, input logic [1:0] p, input logic [3:0] a,
                        input logic [31:0] d, input logic [31:0] fd, input bit junk);
    string tag;
    int    fw;
    int    cyc;
    logic [3:0] pb;
    pb  = 4'b1 << p;
    e_n = 0;
    tag = "R9";
    // expected behaviour from the model
    if (t == 2'd0 || t == 2'd1) begin
      if (m_st[a] == 2) begin
        tag = (t == 2'd0) ? "R6" : "R7";
        push_exp((t == 2'd0) ? 2'd2 : 2'd3, 2'(owner_of(m_sh[a])), 32'h0);
        m_mem[a] = fd;
        push_exp(2'd0, p, fd);
        if (t == 2'd0) begin m_st[a] = 1; m_sh[a] = m_sh[a] | pb; end
        else           begin m_st[a] = 2; m_sh[a] = pb; end
      end else begin
        if (t == 2'd0) tag = (m_st[a] == 0) ? "R2" : "R3";
        else           tag = (m_st[a] == 0) ? "R4" : "R5";
        if (t == 2'd1 && m_st[a] == 1)
          for (int i = 0; i < NP; i++)
            if (m_sh[a][i] && i != int'(p)) push_exp(2'd1, 2'(i), 32'h0);
        push_exp(2'd0, p, m_mem[a]);
        if (t == 2'd0) begin m_st[a] = 1; m_sh[a] = m_sh[a] | pb; end
        else           begin m_st[a] = 2; m_sh[a] = pb; end
      end
    end else begin
      if (m_st[a] == 2 && m_sh[a] == pb) begin
        tag = "R8";
        m_mem[a] = d; m_st[a] = 0; m_sh[a] = '0;
      end
    end
    if (junk) tag = {tag, "/R10"};

    // drive the request for one cycle
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_proc = p; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R1", "busy after accept", 32'(busy), 32'h1);
    o_n = 0; fw = 0; cyc = 0;
    while (busy && cyc < 100) begin
      if (fw > 0) begin
        fw--;
        if (fw == 0) begin
          req_valid = 1'b0; fetch_valid = 1'b1; fetch_data = fd;
        end else if (junk) begin
          req_valid = 1'b1; req_type = 2'd1; req_proc = p + 2'd1;
          req_addr = a + 4'd1; req_data = 32'hDEAD_BEEF;
        end
      end
      if (msg_valid) begin
        if (o_n < 8) begin
          o_t[o_n] = msg_type; o_p[o_n] = msg_proc; o_a[o_n] = msg_addr; o_d[o_n] = msg_data;
        end
        o_n++;
        if (msg_type == 2'd2 || msg_type == 2'd3) fw = junk ? 3 : 1;
      end
      @(negedge clk);
      fetch_valid = 1'b0;
      cyc++;
    end
    req_valid = 1'b0;
    check(o_n == e_n, tag, "message count", 32'(o_n), 32'(e_n));
    for (int k = 0; k < e_n && k < o_n && k < 8; k++) begin
      check(o_t[k] == e_t[k], tag, "msg type", 32'(o_t[k]), 32'(e_t[k]));
      check(o_p[k] == e_p[k], tag, "msg proc", 32'(o_p[k]), 32'(e_p[k]));
      check(o_a[k] == a,      tag, "msg addr", 32'(o_a[k]), 32'(a));
      check(o_d[k] == e_d[k], tag, "msg data", o_d[k], e_d[k]);
    end
    // idle gap: junk must not have started a new request
    @(negedge clk);
    check(!busy && !msg_valid, junk ? "R10" : tag, "idle after request",
          {30'h0, busy, msg_valid}, 32'h0);
  endtask

  logic [31:0] rng;
  int          opn;

  task automatic rand_ops(input int count, input logic [3:0] amask);
    for (int k = 0; k < count; k++) begin
      logic [1:0] t;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      t = (rng[1:0] == 2'd3) ? 2'd0 : rng[1:0];
      opn++;
      do_req(t, rng[3:2], rng[7:4] & amask, 32'hC000_0000 + 32'(opn),
             32'hA500_0000 + 32'(opn), rng[9:8] == 2'd0);
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int e = 0; e < NE; e++) begin m_st[e] = 0; m_sh[e] = '0; m_mem[e] = '0; end
    rst_n = 1'b0; req_valid = 1'b0; req_type = '0; req_proc = '0; req_addr = '0;
    req_data = '0; fetch_valid = 1'b0; fetch_data = '0;
    rng = 32'h1234_5679; opn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R1", "busy after reset", 32'(busy), 32'h0);
    check(msg_valid === 1'b0, "R1", "msg_valid after reset", 32'(msg_valid), 32'h0);

    // directed walk on block 5
    do_req(2'd0, 2'd2, 4'd5, 32'h0, 32'h0, 1'b0);            // R2 from reset data
    do_req(2'd2, 2'd2, 4'd5, 32'h1111_0000, 32'h0, 1'b0);    // R9 shared, no owner
    do_req(2'd1, 2'd1, 4'd5, 32'h0, 32'h0, 1'b0);            // R5 inv P2 only
    do_req(2'd0, 2'd2, 4'd5, 32'h0, 32'h0000_00D1, 1'b0);    // R6 fetch from P1
    do_req(2'd0, 2'd0, 4'd5, 32'h0, 32'h0, 1'b0);            // R3
    do_req(2'd0, 2'd3, 4'd5, 32'h0, 32'h0, 1'b0);            // R3
    do_req(2'd1, 2'd2, 4'd5, 32'h0, 32'h0, 1'b0);            // R5 inv 0,1,3
    do_req(2'd2, 2'd0, 4'd5, 32'h2222_0000, 32'h0, 1'b0);    // R9 non-owner
    do_req(2'd1, 2'd3, 4'd5, 32'h0, 32'h0000_00D2, 1'b1);    // R7 with R10 junk
    do_req(2'd2, 2'd3, 4'd5, 32'h0000_00D3, 32'h0, 1'b0);    // R8
    do_req(2'd1, 2'd0, 4'd5, 32'h0, 32'h0, 1'b0);            // R4 returns D3
    do_req(2'd0, 2'd1, 4'd9, 32'h0, 32'h0, 1'b0);            // R2 other block untouched

    rand_ops(700, 4'h3);
    rand_ops(500, 4'hF);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule